// File: doc/BRIEF.md
# Compare Match Timer Channel

A single timer channel built around an up-counter that advances on a prescaled reference tick. The channel has three registers: a 16-bit control/status word, the counter and a compare value. Each time the counter is stepped and equals the compare value, a sticky match flag is set. The flag then drives an interrupt line or a DMA request line, depending on the request type chosen in the control word. In periodic mode the counter returns to zero after a match. In free-running mode it keeps counting, and a wrap from all ones to zero with no match sets an overflow flag.

Software uses a simple synchronous register port: one write strobe, a two-bit word index, write data and combinational read data. The counter steps only while the external `run` input is high. A write to the counter is not visible at once. It is held and loaded into the counting logic after two counting ticks, which models a counter that runs in a slow clock domain. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag as it is, so software can read the control word, mask it and write it back without losing events.

Top module: `match_timer_ch`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the compare register reads all ones, and `irq` and `dma_req` are low.
- R2: Control bits 2:0 select the counting tick. Code 4 gives one tick per 8 reference ticks, 5 per 32, 6 per 128 and 7 one tick per reference tick. Codes 0 to 3 give no ticks. The divider phase counts reference ticks since reset, and a tick falls on every Nth one.
- R3: The counter does not step while `run` is low. Pending counter loads still complete.
- R4: A step with counter equal to compare sets flag bit 15. With bit 8 clear, the counter then goes on to compare+1.
- R5: With control bit 8 set, a step at counter equal to compare loads zero, so the counter runs from 0 to compare inclusive.
- R6: A step from all ones with no match wraps to zero and sets flag bit 14.
- R7: A control write with bit 15 or bit 14 at 0 clears that flag. A 1 leaves the flag unchanged. A flag set in the same cycle as a clearing write stays set.
- R8: `irq` is high when flag 15 is set, bit 7 is set and bits 5:4 equal 2'b10. `dma_req` is high when flag 15 is set and bits 5:4 equal 2'b01.
- R9: A counter write is loaded on the second counting tick after it. Until then the counter reads its old value and does not step. A step never occurs in the cycle of a counter write, and a new write restarts the wait.
- R10: Index 0 is the control word, 1 the counter, 2 the compare register. Index 3 reads zero. Control bits 13:9, 6 and 3 read zero, and flags cannot be set by a write.
- R11: A compare write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick strobe, one clock wide |
| run | input | 1 | Count enable from the shared start logic |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data of the indexed register |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the channel with an 8-bit counter and a 32-bit data port. With that width, a free-running wrap and the overflow flag, a full periodic cycle and the slowest divider all occur within a few hundred clocks. This keeps every counting mode, the delayed counter load and the flag-clear rules inside one short run, checked against a behavioural model on every clock.

// File: rtl/match_timer_ch.sv
module match_timer_ch #(
  parameter int CNT_W = 32,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             run,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  output logic             dma_req
);
  localparam int PRE_W  = 7;
  localparam int CTRL_W = 16;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic             mf_q, ov_q, per_q, ie_q;
  logic [1:0]       req_q, pend_q;
  logic [2:0]       cks_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, pval_q;
  logic             tick, wr_ctl, wr_cnt, wr_cmp, step, hit, set_mf, set_ov;
  logic [CTRL_W-1:0] ctl_rd;

  always_comb begin
    case (cks_q)
      3'd4:    pre_mask = PRE_W'(7);
      3'd5:    pre_mask = PRE_W'(31);
      3'd6:    pre_mask = PRE_W'(127);
      default: pre_mask = '0;
    endcase
  end

  assign tick   = ref_tick & cks_q[2] & ((pre_q & pre_mask) == pre_mask);
  assign wr_ctl = bus_wr & (bus_addr == 2'd0);
  assign wr_cnt = bus_wr & (bus_addr == 2'd1);
  assign wr_cmp = bus_wr & (bus_addr == 2'd2);
  assign step   = tick & run & (pend_q == 2'd0) & ~wr_cnt;
  assign hit    = cnt_q == cmp_q;
  assign set_mf = step & hit;
  assign set_ov = step & ~hit & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(ref_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pval_q <= '0;
      pend_q <= 2'd0;
    end else if (wr_cnt) begin
      pval_q <= bus_wdata[CNT_W-1:0];
      pend_q <= 2'd2;
    end else if (tick && pend_q != 2'd0) begin
      pend_q <= pend_q - 2'd1;
      if (pend_q == 2'd1) cnt_q <= pval_q;
    end else if (step) begin
      cnt_q <= (hit && per_q) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_q  <= 1'b0;
      ov_q  <= 1'b0;
      per_q <= 1'b0;
      ie_q  <= 1'b0;
      req_q <= 2'd0;
      cks_q <= 3'd0;
    end else begin
      mf_q <= set_mf | (mf_q & ~(wr_ctl & ~bus_wdata[15]));
      ov_q <= set_ov | (ov_q & ~(wr_ctl & ~bus_wdata[14]));
      if (wr_ctl) begin
        per_q <= bus_wdata[8];
        ie_q  <= bus_wdata[7];
        req_q <= bus_wdata[5:4];
        cks_q <= bus_wdata[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  assign ctl_rd = {mf_q, ov_q, 5'b0, per_q, ie_q, 1'b0, req_q, 1'b0, cks_q};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = BUS_W'(ctl_rd);
      2'd1:    bus_rdata = BUS_W'(cnt_q);
      2'd2:    bus_rdata = BUS_W'(cmp_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = mf_q & ie_q & (req_q == 2'b10);
  assign dma_req = mf_q & (req_q == 2'b01);
endmodule

// File: rtl/match_timer_ch_sva.sv
module match_timer_ch_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             wd15,
  input logic             irq,
  input logic             dma_req,
  input logic             tick,
  input logic             mf_q,
  input logic             ov_q,
  input logic             per_q,
  input logic [1:0]       pend_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q
);
  assert_match_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_q) |-> $past(cnt_q) == $past(cmp_q));

  assert_periodic_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && pend_q == 2'd0 && !(bus_wr && bus_addr == 2'd1) && per_q && cnt_q == cmp_q)
    |=> cnt_q == '0);

  assert_overflow_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> ($past(cnt_q) == '1) && (cnt_q == '0));

  assert_halt_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && pend_q == 2'd0) |=> $stable(cnt_q));

  assert_load_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == 2'd2) |=> $stable(cnt_q));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_q && !(bus_wr && bus_addr == 2'd0 && !wd15)) |=> mf_q);

  assert_single_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !dma_req);
endmodule

bind match_timer_ch match_timer_ch_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd15(bus_wdata[15]), .irq(irq), .dma_req(dma_req), .tick(tick),
  .mf_q(mf_q), .ov_q(ov_q), .per_q(per_q), .pend_q(pend_q),
  .cnt_q(cnt_q), .cmp_q(cmp_q)
);

// File: tb/match_timer_ch_test.sv
module match_timer_ch_test;
  localparam int CNT_W = 8;
  localparam int BUS_W = 32;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_tick = 1'b0;
  logic             run = 1'b0;
  logic             bus_wr = 1'b0;
  logic [1:0]       bus_addr = 2'd0;
  logic [BUS_W-1:0] bus_wdata = '0;
  logic [BUS_W-1:0] bus_rdata;
  logic             irq, dma_req;

  match_timer_ch #(.CNT_W(CNT_W), .BUS_W(BUS_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_err = 0;
  string phase = "R1";
  bit    ref_en = 1'b0;
  int    ref_gap = 1;
  int    cyc = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    ref_tick <= ref_en && (cyc % ref_gap == 0);
  end

  int m_pre, m_cnt, m_cmp, m_pend, m_pval, m_req, m_cks, div, ncnt, npend;
  bit m_mf, m_ov, m_per, m_ie, tk, wctl, wcnt, wcmp, stp, smf, sov;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_cmp = MAXV; m_pend = 0; m_pval = 0;
      m_req = 0; m_cks = 0; m_mf = 0; m_ov = 0; m_per = 0; m_ie = 0;
    end else begin
      div  = (m_cks == 4) ? 8 : (m_cks == 5) ? 32 : (m_cks == 6) ? 128 : (m_cks == 7) ? 1 : 0;
      tk   = ref_tick && div != 0 && (m_pre % div == div - 1);
      wctl = bus_wr && bus_addr == 0;
      wcnt = bus_wr && bus_addr == 1;
      wcmp = bus_wr && bus_addr == 2;
      stp  = tk && run && m_pend == 0 && !wcnt;
      smf  = stp && m_cnt == m_cmp;
      sov  = stp && m_cnt != m_cmp && m_cnt == MAXV;
      ncnt = m_cnt; npend = m_pend;
      if (wcnt) begin
        m_pval = int'(bus_wdata) & MAXV; npend = 2;
      end else if (tk && m_pend > 0) begin
        npend = m_pend - 1;
        if (m_pend == 1) ncnt = m_pval;
      end else if (stp) begin
        ncnt = (smf && m_per) ? 0 : (m_cnt + 1) % (MAXV + 1);
      end
      if (wctl && !bus_wdata[15]) m_mf = 0;
      if (wctl && !bus_wdata[14]) m_ov = 0;
      if (smf) m_mf = 1;
      if (sov) m_ov = 1;
      if (wctl) begin
        m_per = bus_wdata[8]; m_ie = bus_wdata[7];
        m_req = int'(bus_wdata[5:4]); m_cks = int'(bus_wdata[2:0]);
      end
      if (wcmp) m_cmp = int'(bus_wdata) & MAXV;
      m_pre = (m_pre + int'(ref_tick)) % 128;
      m_cnt = ncnt; m_pend = npend;
    end
  end

  logic [31:0] exp_rd;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      case (bus_addr)
        2'd0: exp_rd = {16'd0, m_mf, m_ov, 5'd0, m_per, m_ie, 1'b0, 2'(m_req), 1'b0, 3'(m_cks)};
        2'd1: exp_rd = 32'(m_cnt);
        2'd2: exp_rd = 32'(m_cmp);
        default: exp_rd = 32'd0;
      endcase
      chk(bus_rdata, exp_rd, phase);
      chk(32'(irq), 32'(m_mf && m_ie && m_req == 2), {phase, "/R8 irq"});
      chk(32'(dma_req), 32'(m_mf && m_req == 1), {phase, "/R8 dma"});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #2;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    phase = "R1";
    rd(2'd0, 32'd0, "R1 ctrl");
    rd(2'd1, 32'd0, "R1 counter");
    rd(2'd2, 32'(MAXV), "R1 compare");
    chk(32'(irq | dma_req), 32'd0, "R1 requests");

    phase = "R10";
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, 32'h0000_01B7, "R10 ctrl readback");
    rd(2'd3, 32'd0, "R10 index 3");
    wr(2'd0, 32'd0);

    phase = "R2";
    ref_en = 1'b1; run = 1'b1;
    wr(2'd0, 32'h7); idle(40);
    wr(2'd0, 32'h4); idle(100);
    wr(2'd0, 32'h5); idle(200);
    wr(2'd0, 32'h6); idle(600);
    wr(2'd0, 32'h0); idle(50);

    phase = "R3";
    wr(2'd0, 32'h7); run = 1'b0; idle(30);
    run = 1'b1; idle(20); run = 1'b0; idle(10); run = 1'b1;

    phase = "R4";
    wr(2'd2, 32'd20); wr(2'd1, 32'd0); wr(2'd0, 32'h00A7);
    idle(60);
    phase = "R6";
    idle(260);

    phase = "R8";
    wr(2'd0, 32'hC017); idle(10);
    wr(2'd0, 32'hC0A7); idle(10);

    phase = "R7";
    wr(2'd0, 32'hC0A7); idle(3);
    wr(2'd0, 32'h40A7); idle(5);
    wr(2'd0, 32'h00A7); idle(5);

    phase = "R5";
    wr(2'd2, 32'd9); wr(2'd1, 32'd0); wr(2'd0, 32'h0107);
    idle(100);
    ref_gap = 3; idle(60); ref_gap = 1;

    phase = "R9";
    wr(2'd0, 32'h0004); wr(2'd1, 32'd200); idle(40);
    run = 1'b0; wr(2'd1, 32'd50); wr(2'd1, 32'd60); idle(40);
    run = 1'b1; idle(20);

    phase = "R11";
    wr(2'd2, 32'd33);
    rd(2'd2, 32'd33, "R11 compare");
    idle(5);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule